// File: doc/BRIEF.md
# IEC958 AM824 Label Generator

This block turns 16-bit audio samples, each given as a low byte and a high byte, into 32-bit AM824 quadlets for an isochronous audio stream. Every quadlet carries an 8-bit label in its top byte. In the two IEC958 formats, linear PCM and compressed AC3, the label holds the block-start flag, a first-subframe flag, a parity bit and one bit of the channel-status stream. In raw format the label is a fixed constant.

The block counts its own position inside the 192-frame channel-status block. It serializes the channel-status bits from the configured format and a 4-bit sample-rate code, so the packetizer upstream only supplies samples with their subframe index. A configuration strobe loads the format, the rate code and the raw channel count, and restarts the block position. Each accepted sample gives one registered quadlet, with a valid strobe, one cycle later.

Top module: `am824_labeler`

## Requirements
- R1: A frame counter runs over 0..191 and advances by one after the last channel of each accepted event. That channel is subframe 1 in IEC958 formats and subframe chanCount-1 in raw format. After frame 191 it returns to 0.
- R2: The channel-status bit is 1 in frames 2 and 9. In frame 1 it is 1 only when the format is AC3. It is 0 in every frame outside 1, 2, 9 and 24..27.
- R3: In frames 24, 25, 26 and 27 the channel-status bit is bit (27 - frame) of the latched 4-bit rate code. For example, code 0x0C gives 1,1,0,0 and code 0x04 gives 0,1,0,0.
- R4: In IEC958 formats the label bits 7:6 and 1:0 are 0. Bit 2 is the channel-status bit. Bit 4 is 1 exactly on subframe 0. Bit 5 is 1 only on subframe 0 of frame 0.
- R5: Label bit 3 is the even parity of the 16 sample bits together with the channel-status bit, so the XOR of all those bits and bit 3 is 0.
- R6: The quadlet is {label, high byte, low byte, 8'h00}, most significant byte first on quadOut[31:0]. quadValid is high for one cycle, one clock after each accepted sample.
- R7: Format code 0 is PCM and code 1 is AC3. Codes 2 and 3 are raw: the label is 0x40, no IEC958 bits are produced, and any subframe index is accepted.
- R8: In IEC958 formats a sample with a subframe index of 2 or more produces no quadlet and does not move the frame counter.
- R9: On cfgLoad the block latches format, rate code and channel count and clears the frame counter. A sample offered in the same cycle is dropped. Configuration inputs have no effect at any other time.
- R10: After reset quadValid is 0, the frame counter is 0, and the latched format is PCM with rate code 0 and two channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Configuration strobe: latch settings, restart block |
| fmtIn | input | 2 | Format code (0 PCM, 1 AC3, 2/3 raw) |
| rateIn | input | 4 | Channel-status rate code |
| chanIn | input | SUB_W | Channels per event in raw format |
| sampleValid | input | 1 | Sample present |
| sampleLo | input | 8 | Low sample byte |
| sampleHi | input | 8 | High sample byte |
| subIdx | input | SUB_W | Channel (subframe) index of the sample |
| quadValid | output | 1 | Output quadlet valid |
| quadOut | output | 32 | AM824 quadlet, label in bits 31:24 |

## Verification
On every cycle the assertions check the following. The counter wraps only from 191 to 0. A configuration strobe clears the counter. Every accepted sample is followed by a quadlet, and an out-of-range IEC958 subframe is not. Each emitted IEC958 label has consistent parity, a block-start flag only together with the subframe flag, and a zero low byte in the quadlet. The actual channel-status sequence can only be shown by the bench scenarios: the bits of frames 1, 2, 9 and 24..27 for each format and rate, the wrap of a full block, the restart after reconfiguration, and the inputs that are ignored.

// File: rtl/am824_pkg.sv
package am824_pkg;
  localparam int FRAMES_PER_BLOCK = 192;
  localparam int RATE_BITS = 4;
  localparam logic [1:0] FMT_PCM = 2'd0;
  localparam logic [1:0] FMT_AC3 = 2'd1;
  localparam logic [7:0] RAW_LABEL = 8'h40;
  localparam int CS_FRAME_AC3 = 1;
  localparam int CS_FRAME_ONE_A = 2;
  localparam int CS_FRAME_ONE_B = 9;
  localparam int CS_RATE_FIRST = 24;
  localparam int CS_RATE_LAST = 27;

  typedef struct packed {
    logic accept;
    logic csBit;
    logic blockStart;
    logic isRaw;
  } strobe_t;
endpackage

// File: rtl/am824_ctrl.sv
module am824_ctrl
  import am824_pkg::*;
#(
  parameter int FRAMES = FRAMES_PER_BLOCK,
  parameter int SUB_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgLoad,
  input  logic [1:0]           fmtIn,
  input  logic [RATE_BITS-1:0] rateIn,
  input  logic [SUB_W-1:0]     chanIn,
  input  logic                 sampleValid,
  input  logic [SUB_W-1:0]     subIdx,
  output strobe_t              strb
);
  localparam int CNT_W = $clog2(FRAMES);

  logic [1:0]           fmtReg;
  logic [RATE_BITS-1:0] rateReg;
  logic [SUB_W-1:0]     chanReg;
  logic [CNT_W-1:0]     frameCnt;
  logic                 isRaw, lastCh, accept, csBit;
  logic [CNT_W-1:0]     rateIdx;

  assign isRaw  = fmtReg[1];
  assign accept = sampleValid && !cfgLoad && (isRaw || subIdx < SUB_W'(2));
  assign lastCh = isRaw ? (subIdx == SUB_W'(chanReg - 1'b1)) : (subIdx == SUB_W'(1));
  assign rateIdx = CNT_W'(CS_RATE_LAST) - frameCnt;

  always_comb begin
    csBit = 1'b0;
    if (frameCnt == CNT_W'(CS_FRAME_AC3))
      csBit = (fmtReg == FMT_AC3);
    else if (frameCnt == CNT_W'(CS_FRAME_ONE_A) || frameCnt == CNT_W'(CS_FRAME_ONE_B))
      csBit = 1'b1;
    else if (frameCnt >= CNT_W'(CS_RATE_FIRST) && frameCnt <= CNT_W'(CS_RATE_LAST))
      csBit = rateReg[rateIdx[1:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtReg   <= FMT_PCM;
      rateReg  <= '0;
      chanReg  <= SUB_W'(2);
      frameCnt <= '0;
    end else if (cfgLoad) begin
      fmtReg   <= fmtIn;
      rateReg  <= rateIn;
      chanReg  <= chanIn;
      frameCnt <= '0;
    end else if (accept && lastCh) begin
      frameCnt <= (frameCnt == CNT_W'(FRAMES - 1)) ? '0 : frameCnt + 1'b1;
    end
  end

  assign strb.accept     = accept;
  assign strb.csBit      = csBit;
  assign strb.blockStart = (frameCnt == '0) && (subIdx == '0);
  assign strb.isRaw      = isRaw;

  // R1: wrap goes back to zero only after the last frame
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (accept && lastCh && frameCnt == CNT_W'(FRAMES - 1)) |=> (frameCnt == '0));
  // R9: reconfiguration restarts the block
  a_r9_cfg_clear: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> (frameCnt == '0));
endmodule

// File: rtl/am824_dp.sv
module am824_dp
  import am824_pkg::*;
#(
  parameter int SUB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [7:0]       sampleLo,
  input  logic [7:0]       sampleHi,
  input  logic [SUB_W-1:0] subIdx,
  output logic             quadValid,
  output logic [31:0]      quadOut
);
  logic [23:0] sampleWord;
  logic        parityBit;
  logic [7:0]  label;

  assign sampleWord = {sampleHi, sampleLo, 8'h00};
  assign parityBit  = ^{sampleWord, strb.csBit};

  always_comb begin
    if (strb.isRaw)
      label = RAW_LABEL;
    else
      label = {2'b00, strb.blockStart, (subIdx == '0), parityBit, strb.csBit, 2'b00};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quadValid <= 1'b0;
      quadOut   <= '0;
    end else begin
      quadValid <= strb.accept;
      if (strb.accept) quadOut <= {label, sampleWord};
    end
  end

  // R6: every accepted sample yields a quadlet on the next cycle
  a_r6_latency: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> quadValid);
  // R6: the low byte of the quadlet is always zero
  a_r6_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    quadValid |-> (quadOut[7:0] == 8'h00));
  // R4: block start only appears together with the first-subframe flag
  a_r4_block_start: assert property (@(posedge clk) disable iff (!rstN)
    (quadValid && quadOut[31:24] != RAW_LABEL && quadOut[29]) |-> quadOut[28]);
  // R5: the emitted IEC958 label is parity-consistent
  a_r5_parity: assert property (@(posedge clk) disable iff (!rstN)
    (quadValid && quadOut[31:24] != RAW_LABEL) |-> ((^{quadOut[23:8], quadOut[26], quadOut[27]}) == 1'b0));
endmodule

// File: rtl/am824_labeler.sv
module am824_labeler
  import am824_pkg::*;
#(
  parameter int FRAMES = FRAMES_PER_BLOCK,
  parameter int SUB_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [1:0]       fmtIn,
  input  logic [3:0]       rateIn,
  input  logic [SUB_W-1:0] chanIn,
  input  logic             sampleValid,
  input  logic [7:0]       sampleLo,
  input  logic [7:0]       sampleHi,
  input  logic [SUB_W-1:0] subIdx,
  output logic             quadValid,
  output logic [31:0]      quadOut
);
  strobe_t strb;

  am824_ctrl #(.FRAMES(FRAMES), .SUB_W(SUB_W)) ctrlInst (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .fmtIn(fmtIn), .rateIn(rateIn),
    .chanIn(chanIn), .sampleValid(sampleValid), .subIdx(subIdx), .strb(strb)
  );

  am824_dp #(.SUB_W(SUB_W)) dpInst (
    .clk(clk), .rstN(rstN), .strb(strb), .sampleLo(sampleLo), .sampleHi(sampleHi),
    .subIdx(subIdx), .quadValid(quadValid), .quadOut(quadOut)
  );

  // R8: an out-of-range IEC958 subframe produces no quadlet
  a_r8_two_channels: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !strb.isRaw && subIdx >= SUB_W'(2)) |=> !quadValid);
  // R9: a sample offered with the configuration strobe is dropped
  a_r9_cfg_drop: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> !quadValid);
endmodule

// File: tb/am824_labeler_test.sv
module am824_labeler_test;
  localparam int SUB_W = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0;
  logic [1:0] fmtIn = 2'd0;
  logic [3:0] rateIn = 4'd0;
  logic [SUB_W-1:0] chanIn = 4'd2;
  logic sampleValid = 1'b0;
  logic [7:0] sampleLo = 8'd0, sampleHi = 8'd0;
  logic [SUB_W-1:0] subIdx = '0;
  logic quadValid;
  logic [31:0] quadOut;

  int total = 0, failed = 0;
  int mFrame = 0, mFmt = 0, mRate = 0, mChan = 2;

  always #2 clk = ~clk;

  am824_labeler #(.SUB_W(SUB_W)) uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .fmtIn(fmtIn), .rateIn(rateIn),
    .chanIn(chanIn), .sampleValid(sampleValid), .sampleLo(sampleLo), .sampleHi(sampleHi),
    .subIdx(subIdx), .quadValid(quadValid), .quadOut(quadOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expQuad(input int frame, input int sub, input logic [7:0] hi, input logic [7:0] lo);
    logic cs, par;
    if (mFmt >= 2) return {8'h40, hi, lo, 8'h00};
    cs = 1'b0;
    if (frame == 1) cs = (mFmt == 1);
    else if (frame == 2 || frame == 9) cs = 1'b1;
    else if (frame >= 24 && frame <= 27) cs = mRate[27 - frame];
    par = ^{hi, lo, cs};
    return {2'b00, (frame == 0 && sub == 0), (sub == 0), par, cs, 2'b00, hi, lo, 8'h00};
  endfunction

  function automatic string tagFor(input int frame, input int sub);
    if (mFmt >= 2) return "R7";
    if (frame == 0) return "R1";
    if (frame == 1 || frame == 2 || frame == 9) return "R2";
    if (frame >= 24 && frame <= 27) return "R3";
    return (sub == 0) ? "R4" : "R5";
  endfunction

  task automatic configure(input int fmt, input int rate, input int chan);
    @(negedge clk);
    fmtIn = 2'(fmt); rateIn = 4'(rate); chanIn = SUB_W'(chan); cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    mFmt = fmt; mRate = rate; mChan = chan; mFrame = 0;
  endtask

  task automatic sendOne(input int sub, input logic [7:0] hi, input logic [7:0] lo);
    bit ok;
    int lastSub;
    ok = (mFmt >= 2) || (sub < 2);
    sampleValid = 1'b1; subIdx = SUB_W'(sub); sampleHi = hi; sampleLo = lo;
    @(negedge clk);
    sampleValid = 1'b0;
    if (ok) begin
      check("R6", {31'd0, quadValid}, 32'd1);
      check(tagFor(mFrame, sub), quadOut, expQuad(mFrame, sub, hi, lo));
      lastSub = (mFmt >= 2) ? mChan - 1 : 1;
      if (sub == lastSub) mFrame = (mFrame == 191) ? 0 : mFrame + 1;
    end else begin
      check("R8", {31'd0, quadValid}, 32'd0);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R10", {31'd0, quadValid}, 32'd0);
    sendOne(0, 8'h12, 8'h34);
    sendOne(1, 8'hA5, 8'h01);
  endtask

  task automatic testPcmBlock();
    configure(0, 4'hC, 2);
    for (int f = 0; f < 194; f++) begin
      sendOne(0, 8'(f * 7), 8'(f ^ 8'h5A));
      sendOne(1, 8'(~f), 8'(f * 3 + 1));
    end
  endtask

  task automatic testAc3Rate48();
    configure(1, 4'h4, 2);
    for (int f = 0; f < 30; f++) begin
      sendOne(0, 8'hFF, 8'(f));
      sendOne(1, 8'h00, 8'(f + 9));
    end
  endtask

  task automatic testSubReject();
    configure(0, 4'hC, 2);
    sendOne(0, 8'h11, 8'h22);
    sendOne(2, 8'h33, 8'h44);
    sendOne(3, 8'h55, 8'h66);
    sendOne(1, 8'h77, 8'h88);
    sendOne(0, 8'h99, 8'hAA);
  endtask

  task automatic testRaw();
    configure(2, 4'h0, 5);
    for (int e = 0; e < 3; e++)
      for (int c = 0; c < 5; c++) sendOne(c, 8'(e + c), 8'hC3);
    configure(3, 4'h0, 3);
    sendOne(7, 8'h01, 8'h02);
  endtask

  task automatic testCfg();
    configure(0, 4'h4, 2);
    for (int f = 0; f < 10; f++) begin
      sendOne(0, 8'h10, 8'(f)); sendOne(1, 8'h20, 8'(f));
    end
    fmtIn = 2'd2; rateIn = 4'hF;
    sendOne(0, 8'h3C, 8'h00);
    sendOne(1, 8'h3C, 8'h01);
    @(negedge clk);
    fmtIn = 2'd0; rateIn = 4'h4; cfgLoad = 1'b1;
    sampleValid = 1'b1; subIdx = '0; sampleHi = 8'hEE; sampleLo = 8'hEE;
    @(negedge clk);
    cfgLoad = 1'b0; sampleValid = 1'b0; mFrame = 0;
    check("R9", {31'd0, quadValid}, 32'd0);
    sendOne(0, 8'h01, 8'h80);
    sendOne(1, 8'h02, 8'h40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPcmBlock();
    testAc3Rate48();
    testSubReject();
    testRaw();
    testCfg();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule